// File: doc/BRIEF.md
# Serial Command Framer with Q-Scan Repeat

This block turns host register writes into a command message on a byte-serial loop. The host loads a 6-bit crate address, a 16-bit command word and 24 bits of write data. Once the transfer is triggered, the block sends a fixed sequence of framed link bytes on an 8-bit output, one byte per strobe:

- the crate, station, subaddress and function bytes;
- for write functions, four data bytes;
- a column-parity sum byte;
- a parameterised number of space bytes;
- two closing wait bytes.

After the message the link goes back to continuous idle bytes.

A separate receiver reports the outcome of each transfer: a reply with its Q bit, or a timeout. The block uses that outcome to raise its ready flag. When repeat mode is set, a host read of the low received-data word re-launches the current read command. In scan mode the repeat first steps the subaddress or the station, depending on the last Q. When the station runs past its limit, the crate address is forced to zero, so the loop answers "address not recognised" and the scan ends.

Top module: `sh_cmd_framer`

## Requirements
- R1: Every link byte has its payload in bits 0-5, a delimiter in bit 6 and bit 7 chosen so the byte has odd parity. Message bytes have delimiter 0. The idle byte and the end (wait) byte are 0x40. The space byte is 0x80.
- R2: A message opens with four bytes, in this order:
  - the crate address;
  - the station byte (station in bits 0-4, bit 5 = 1);
  - the subaddress byte (subaddress in bits 0-3, bits 4-5 = 0);
  - the function byte (function in bits 0-4, bit 5 = 1).

  The command word holds the function in bits 0-4, the subaddress in bits 5-8, the station in bits 9-13, the repeat bit in bit 14 and the scan bit in bit 15.
- R3: Write functions are 16-23 (function bits 4:3 = 10). A write message carries four more data bytes after the function byte: data bits 23:18, then 17:12, then 11:6, then 5:0. Read and control messages carry no data bytes.
- R4: A command write with a read or control function starts a transfer. A write function starts a transfer only on a write of the low data word. A command write with a write function, and any write of the high data byte, sends nothing.
- R5: After the last payload byte come:
  - a sum byte whose payload is the XOR of the payloads of all preceding message bytes;
  - SPACE_CNT space bytes;
  - two end bytes.
- R6: The transmit-done flag rises together with the strobe of the last end byte. It is cleared by the next started transfer.
- R7: Ready rises when a reply or a timeout arrives for the transfer in flight. The timeout flag rises with a timeout. Both clear only when a new transfer starts.
- R8: A reply that arrives after a timeout is ignored. Ready and the timeout flag are unchanged, and the Q it carries is not used by a later scan step.
- R9: While a transfer is awaiting its reply or still transmitting, host writes and starts are ignored.
- R10: With repeat set, scan clear and a read function, a low-data read after ready resends the identical message.
- R11: With repeat and scan set and last Q = 1, the repeat uses the subaddress plus one.
- R12: With repeat and scan set and last Q = 0, the repeat clears the subaddress and advances the station. A station above 24 forces crate address 0.
- R13: With repeat clear, a low-data read starts nothing.
- R14: The output strobe pulses once every BYTE_CYC clock cycles, and the byte changes only with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| crate_we | input | 1 | Crate address write |
| crate_wdata | input | 6 | Crate address |
| cmd_we | input | 1 | Command word write (low byte completes it) |
| cmd_wdata | input | 16 | Command word |
| wdata_hi_we | input | 1 | High write-data byte write |
| wdata_hi | input | 8 | Write data bits 23:16 |
| wdata_lo_we | input | 1 | Low write-data word write |
| wdata_lo | input | 16 | Write data bits 15:0 |
| rdata_lo_rd | input | 1 | Host read of low received-data word |
| rx_done | input | 1 | Reply received pulse |
| rx_q | input | 1 | Q of the received reply |
| rx_timeout | input | 1 | Reply timeout pulse |
| tx_byte | output | 8 | Link byte |
| tx_stb | output | 1 | Link byte strobe |
| tx_done | output | 1 | Message fully transmitted |
| ready | output | 1 | Reply or timeout received |
| timed_out | output | 1 | Transfer ended by timeout |

## Verification
A trigger is registered once, so the first message byte appears at the first byte slot after the trigger; that can be up to BYTE_CYC+1 cycles later. The checks therefore skip idle bytes and compare the stream strobe by strobe, sampling only at falling edges where the strobe is high. Transmit-done is sampled together with the last end byte. Ready and the timeout flag are registered one edge after the reply pulse, so they are read at the falling edge that ends the pulse. "Nothing starts" cases are judged over six following byte slots, which must all be idle.

// File: rtl/sh_frm_pkg.sv
package sh_frm_pkg;

  typedef struct packed {
    logic       mq;
    logic       mr;
    logic [4:0] st;
    logic [3:0] sa;
    logic [4:0] fn;
  } cmd_t;

  // payload in 5:0, delimiter in 6, bit 7 makes the byte odd
  function automatic logic [7:0] link_byte(input logic [5:0] p, input logic delim);
    return {~(^{delim, p}), delim, p};
  endfunction

  localparam logic [7:0] IDLE_BYTE  = 8'h40;
  localparam logic [7:0] SPACE_BYTE = 8'h80;

  function automatic logic fn_is_write(input logic [4:0] f);
    return f[4:3] == 2'b10;
  endfunction

  function automatic logic fn_is_read(input logic [4:0] f);
    return f[4:3] == 2'b00;
  endfunction

  function automatic logic [5:0] msg_payload(input logic [3:0] idx, input logic [5:0] crate,
                                             input cmd_t c, input logic [23:0] d);
    case (idx)
      4'd0:    return crate;
      4'd1:    return {1'b1, c.st};
      4'd2:    return {2'b00, c.sa};
      4'd3:    return {1'b1, c.fn};
      4'd4:    return d[23:18];
      4'd5:    return d[17:12];
      4'd6:    return d[11:6];
      default: return d[5:0];
    endcase
  endfunction

  // next command of a Q-driven scan: returns {crate, command}
  function automatic logic [21:0] scan_step(input logic [5:0] crate, input cmd_t c,
                                            input logic q, input int unsigned max_st);
    cmd_t       n;
    logic [5:0] cr;
    logic [5:0] st_next;
    n  = c;
    cr = crate;
    if (q) begin
      n.sa = c.sa + 4'd1;
    end else begin
      st_next = {1'b0, c.st} + 6'd1;
      n.sa    = 4'd0;
      n.st    = st_next[4:0];
      if (32'(st_next) > max_st) cr = 6'd0;
    end
    return {cr, n};
  endfunction

endpackage

// File: rtl/sh_host_regs.sv
module sh_host_regs
  import sh_frm_pkg::*;
#(
  parameter int unsigned MAX_STATION = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        crate_we,
  input  logic [5:0]  crate_wdata,
  input  logic        cmd_we,
  input  logic [15:0] cmd_wdata,
  input  logic        wdata_hi_we,
  input  logic [7:0]  wdata_hi,
  input  logic        wdata_lo_we,
  input  logic [15:0] wdata_lo,
  input  logic        rdata_lo_rd,
  input  logic        rx_done,
  input  logic        rx_q,
  input  logic        rx_timeout,
  input  logic        seq_busy,
  output logic [5:0]  crate_o,
  output cmd_t        cmd_o,
  output logic [23:0] data_o,
  output logic        start_p,
  output logic        pending,
  output logic        trig,
  output logic        ready,
  output logic        timed_out
);

  logic busy, trig_cmd, trig_dat, trig_rep, q_last;
  cmd_t cmd_new;

  assign cmd_new  = cmd_t'(cmd_wdata);
  assign busy     = pending | seq_busy | start_p;
  assign trig_cmd = cmd_we && !busy && !fn_is_write(cmd_new.fn);
  assign trig_dat = wdata_lo_we && !busy && !cmd_we && fn_is_write(cmd_o.fn);
  assign trig_rep = rdata_lo_rd && !busy && ready && cmd_o.mr && fn_is_read(cmd_o.fn);
  assign trig     = trig_cmd | trig_dat | trig_rep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crate_o   <= '0;
      cmd_o     <= '0;
      data_o    <= '0;
      start_p   <= 1'b0;
      pending   <= 1'b0;
      ready     <= 1'b0;
      timed_out <= 1'b0;
      q_last    <= 1'b0;
    end else begin
      start_p <= trig;
      if (!busy) begin
        if (crate_we)    crate_o        <= crate_wdata;
        if (cmd_we)      cmd_o          <= cmd_new;
        if (wdata_hi_we) data_o[23:16]  <= wdata_hi;
        if (wdata_lo_we) data_o[15:0]   <= wdata_lo;
      end
      if (trig_rep && cmd_o.mq)
        {crate_o, cmd_o} <= scan_step(crate_o, cmd_o, q_last, MAX_STATION);
      if (trig) begin
        pending   <= 1'b1;
        ready     <= 1'b0;
        timed_out <= 1'b0;
      end else if (pending && (rx_done || rx_timeout)) begin
        pending   <= 1'b0;
        ready     <= 1'b1;
        timed_out <= rx_timeout;
        q_last    <= rx_timeout ? 1'b0 : rx_q;
      end
    end
  end

endmodule

// File: rtl/sh_link_seq.sv
module sh_link_seq
  import sh_frm_pkg::*;
#(
  parameter int unsigned SPACE_CNT = 3,
  parameter int unsigned BYTE_CYC  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_p,
  input  logic [5:0]  crate,
  input  cmd_t        cmd,
  input  logic [23:0] data,
  output logic [7:0]  tx_byte,
  output logic        tx_stb,
  output logic        tx_done,
  output logic        seq_busy
);

  localparam int unsigned CNT_W    = (BYTE_CYC > 1) ? $clog2(BYTE_CYC) : 1;
  localparam int unsigned LAST_MAX = 8 + 1 + SPACE_CNT + 2 - 1;
  localparam int unsigned IDX_W    = $clog2(LAST_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx, idx_eff, npay, last_idx;
  logic [5:0]       sum, sum_eff, pay;
  logic [7:0]       cur;
  logic             slot, go, active, emit;

  assign slot     = (cnt == CNT_W'(BYTE_CYC - 1));
  assign emit     = slot && (active || go);
  assign seq_busy = go | active;
  assign npay     = fn_is_write(cmd.fn) ? IDX_W'(8) : IDX_W'(4);
  assign last_idx = npay + IDX_W'(SPACE_CNT + 2);
  assign idx_eff  = active ? idx : '0;
  assign sum_eff  = active ? sum : '0;
  assign pay      = msg_payload(idx_eff[3:0], crate, cmd, data);

  always_comb begin
    if (idx_eff < npay)                            cur = link_byte(pay, 1'b0);
    else if (idx_eff == npay)                      cur = link_byte(sum_eff, 1'b0);
    else if (idx_eff <= npay + IDX_W'(SPACE_CNT))  cur = SPACE_BYTE;
    else                                           cur = IDLE_BYTE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tx_stb  <= 1'b0;
      tx_byte <= IDLE_BYTE;
      tx_done <= 1'b0;
      go      <= 1'b0;
      active  <= 1'b0;
      idx     <= '0;
      sum     <= '0;
    end else begin
      cnt    <= slot ? '0 : cnt + CNT_W'(1);
      tx_stb <= slot;
      if (start_p) begin
        go      <= 1'b1;
        tx_done <= 1'b0;
      end
      if (emit) begin
        go      <= 1'b0;
        tx_byte <= cur;
        sum     <= (idx_eff < npay) ? (sum_eff ^ pay) : sum_eff;
        if (idx_eff == last_idx) begin
          active  <= 1'b0;
          idx     <= '0;
          tx_done <= 1'b1;
        end else begin
          active <= 1'b1;
          idx    <= idx_eff + IDX_W'(1);
        end
      end else if (slot) begin
        tx_byte <= IDLE_BYTE;
      end
    end
  end

endmodule

// File: rtl/sh_cmd_framer.sv
module sh_cmd_framer
  import sh_frm_pkg::*;
#(
  parameter int unsigned SPACE_CNT   = 3,
  parameter int unsigned BYTE_CYC    = 4,
  parameter int unsigned MAX_STATION = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        crate_we,
  input  logic [5:0]  crate_wdata,
  input  logic        cmd_we,
  input  logic [15:0] cmd_wdata,
  input  logic        wdata_hi_we,
  input  logic [7:0]  wdata_hi,
  input  logic        wdata_lo_we,
  input  logic [15:0] wdata_lo,
  input  logic        rdata_lo_rd,
  input  logic        rx_done,
  input  logic        rx_q,
  input  logic        rx_timeout,
  output logic [7:0]  tx_byte,
  output logic        tx_stb,
  output logic        tx_done,
  output logic        ready,
  output logic        timed_out
);

  logic [5:0]  crate;
  cmd_t        cmd;
  logic [23:0] data;
  logic        start_p, pending, trig, seq_busy;

  sh_host_regs #(.MAX_STATION(MAX_STATION)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .crate_we(crate_we), .crate_wdata(crate_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .wdata_hi_we(wdata_hi_we), .wdata_hi(wdata_hi),
    .wdata_lo_we(wdata_lo_we), .wdata_lo(wdata_lo),
    .rdata_lo_rd(rdata_lo_rd),
    .rx_done(rx_done), .rx_q(rx_q), .rx_timeout(rx_timeout),
    .seq_busy(seq_busy),
    .crate_o(crate), .cmd_o(cmd), .data_o(data),
    .start_p(start_p), .pending(pending), .trig(trig),
    .ready(ready), .timed_out(timed_out)
  );

  sh_link_seq #(.SPACE_CNT(SPACE_CNT), .BYTE_CYC(BYTE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_p(start_p),
    .crate(crate), .cmd(cmd), .data(data),
    .tx_byte(tx_byte), .tx_stb(tx_stb), .tx_done(tx_done), .seq_busy(seq_busy)
  );

endmodule

// File: rtl/sh_cmd_framer_chk.sv
module sh_cmd_framer_chk #(
  parameter int unsigned BYTE_CYC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] tx_byte,
  input logic       tx_stb,
  input logic       tx_done,
  input logic       ready,
  input logic       timed_out,
  input logic       start_p,
  input logic       pending,
  input logic       seq_busy
);

  a_r1_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |-> (^tx_byte) == 1'b1);

  a_r1_idle_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stb && !seq_busy) |-> tx_byte == 8'h40);

  a_r6_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !seq_busy);

  a_r6_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !tx_done);

  a_r7_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> !ready);

  a_r7_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> start_p);

  a_r7_timeout_ready: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> ready);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> (!$past(pending) && !$past(seq_busy)));

  generate
    if (BYTE_CYC > 1) begin : g_gap
      a_r14_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |=> !tx_stb);
      a_r14_byte_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_stb |-> $stable(tx_byte));
    end
  endgenerate

endmodule

bind sh_cmd_framer sh_cmd_framer_chk #(.BYTE_CYC(BYTE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_stb(tx_stb),
  .tx_done(tx_done), .ready(ready), .timed_out(timed_out),
  .start_p(start_p), .pending(pending), .seq_busy(seq_busy)
);

// File: tb/sh_cmd_framer_tb.sv
module sh_cmd_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SP = 3;
  localparam int BC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic crate_we = 0, cmd_we = 0, wdata_hi_we = 0, wdata_lo_we = 0, rdata_lo_rd = 0;
  logic rx_done = 0, rx_q = 0, rx_timeout = 0;
  logic [5:0] crate_wdata = 0;
  logic [15:0] cmd_wdata = 0, wdata_lo = 0;
  logic [7:0] wdata_hi = 0;
  logic [7:0] tx_byte;
  logic tx_stb, tx_done, ready, timed_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit wd_hit = 0;

  sh_cmd_framer #(.SPACE_CNT(SP), .BYTE_CYC(BC), .MAX_STATION(24)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !wd_hit) begin
      wd_hit = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d exp<100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fb(input logic [5:0] p, input logic d);
    int ones = $countones({d, p});
    return {(ones % 2 == 0) ? 1'b1 : 1'b0, d, p};
  endfunction

  function automatic logic [15:0] mk_cmd(input bit mq, input bit mr, input int st, input int sa, input int fn);
    return {mq, mr, 5'(st), 4'(sa), 5'(fn)};
  endfunction

  task automatic pulse_crate(input int v);
    @(negedge clk); crate_we = 1; crate_wdata = 6'(v); @(negedge clk); crate_we = 0;
  endtask
  task automatic pulse_cmd(input logic [15:0] v);
    @(negedge clk); cmd_we = 1; cmd_wdata = v; @(negedge clk); cmd_we = 0;
  endtask
  task automatic pulse_dhi(input int v);
    @(negedge clk); wdata_hi_we = 1; wdata_hi = 8'(v); @(negedge clk); wdata_hi_we = 0;
  endtask
  task automatic pulse_dlo(input int v);
    @(negedge clk); wdata_lo_we = 1; wdata_lo = 16'(v); @(negedge clk); wdata_lo_we = 0;
  endtask
  task automatic pulse_rd();
    @(negedge clk); rdata_lo_rd = 1; @(negedge clk); rdata_lo_rd = 0;
  endtask
  task automatic reply(input bit q);
    @(negedge clk); rx_done = 1; rx_q = q; @(negedge clk); rx_done = 0; rx_q = 0;
  endtask
  task automatic timeout();
    @(negedge clk); rx_timeout = 1; @(negedge clk); rx_timeout = 0;
  endtask

  task automatic next_byte(output logic [7:0] b);
    do @(negedge clk); while (!tx_stb);
    b = tx_byte;
  endtask

  task automatic expect_msg(input int cr, input int st, input int sa, input int fn,
                            input int dat, input string req);
    logic [7:0] exp [0:32];
    logic [5:0] s = 0;
    logic [7:0] b;
    logic [5:0] pl [0:7];
    int np = (fn >= 16 && fn <= 23) ? 8 : 4;
    int n = 0;
    int guard = 0;
    pl[0] = 6'(cr); pl[1] = {1'b1, 5'(st)}; pl[2] = {2'b00, 4'(sa)}; pl[3] = {1'b1, 5'(fn)};
    pl[4] = 6'(dat >> 18); pl[5] = 6'(dat >> 12); pl[6] = 6'(dat >> 6); pl[7] = 6'(dat);
    for (int i = 0; i < np; i++) begin exp[n] = fb(pl[i], 0); s = s ^ pl[i]; n++; end
    exp[n] = fb(s, 0); n++;
    for (int i = 0; i < SP; i++) begin exp[n] = 8'h80; n++; end
    exp[n] = 8'h40; exp[n+1] = 8'h40; n += 2;
    next_byte(b);
    while (b == 8'h40 && guard < 12) begin next_byte(b); guard++; end
    check(b == exp[0], {req, " first byte"}, b, exp[0]);
    for (int i = 1; i < n; i++) begin
      next_byte(b);
      check(b == exp[i], $sformatf("%s byte %0d", req, i), b, exp[i]);
    end
    check(tx_done == 1'b1, "R6 done with last end byte", tx_done, 1);
  endtask

  task automatic expect_quiet(input string req);
    logic [7:0] b;
    bit ok = 1;
    for (int i = 0; i < 6; i++) begin next_byte(b); if (b != 8'h40) ok = 0; end
    check(ok, {req, " nothing sent"}, b, 8'h40);
  endtask

  task automatic t_reset();
    logic [7:0] b;
    check(tx_done == 0 && ready == 0 && timed_out == 0, "R7 reset flags",
          {tx_done, ready, timed_out}, 0);
    next_byte(b);
    check(b == 8'h40, "R1 idle byte after reset", b, 8'h40);
  endtask

  task automatic t_pacing();
    int c = 0;
    logic [7:0] b;
    next_byte(b);
    do begin @(negedge clk); c++; end while (!tx_stb);
    check(c == BC, "R14 strobe period", c, BC);
  endtask

  task automatic t_read();
    pulse_crate(5);
    pulse_cmd(mk_cmd(0, 0, 7, 2, 0));
    expect_msg(5, 7, 2, 0, 0, "R2 R5 read frame");
    reply(1);
    check(ready == 1 && timed_out == 0, "R7 ready on reply", {ready, timed_out}, 2);
  endtask

  task automatic t_write();
    pulse_dhi(8'hAB);
    pulse_cmd(mk_cmd(0, 0, 3, 1, 16));
    expect_quiet("R4 write function on command");
    check(ready == 1, "R4 ready untouched by non-start", ready, 1);
    pulse_dlo(16'h1234);
    expect_msg(5, 3, 1, 16, 24'hAB1234, "R3 write frame");
    reply(0);
  endtask

  task automatic t_control_tmo();
    pulse_cmd(mk_cmd(0, 0, 30, 0, 26));
    expect_msg(5, 30, 0, 26, 0, "R4 control starts on command");
    timeout();
    check(ready == 1 && timed_out == 1, "R7 timeout flags", {ready, timed_out}, 3);
  endtask

  task automatic t_busy();
    pulse_crate(9);
    pulse_cmd(mk_cmd(0, 0, 4, 1, 1));
    expect_msg(9, 4, 1, 1, 0, "R9 base frame");
    pulse_crate(20);
    pulse_cmd(mk_cmd(0, 0, 5, 5, 0));
    expect_quiet("R9 command while pending");
    check(ready == 0, "R9 ready still low while pending", ready, 0);
    reply(1);
    pulse_cmd(mk_cmd(0, 0, 6, 3, 0));
    expect_msg(9, 6, 3, 0, 0, "R9 crate write ignored");
    reply(1);
  endtask

  task automatic t_no_repeat();
    pulse_rd();
    expect_quiet("R13 read without repeat");
  endtask

  task automatic t_repeat_same();
    pulse_cmd(mk_cmd(0, 1, 6, 4, 2));
    expect_msg(9, 6, 4, 2, 0, "R10 first");
    reply(0);
    pulse_rd();
    expect_msg(9, 6, 4, 2, 0, "R10 identical repeat");
    reply(1);
  endtask

  task automatic t_scan();
    pulse_cmd(mk_cmd(1, 1, 6, 4, 0));
    expect_msg(9, 6, 4, 0, 0, "R11 first");
    reply(1);
    pulse_rd();
    expect_msg(9, 6, 5, 0, 0, "R11 subaddress step");
    reply(0);
    pulse_rd();
    expect_msg(9, 7, 0, 0, 0, "R12 station step");
    reply(0);
    pulse_cmd(mk_cmd(1, 1, 24, 3, 0));
    expect_msg(9, 24, 3, 0, 0, "R12 last station");
    reply(0);
    pulse_rd();
    expect_msg(0, 25, 0, 0, 0, "R12 crate forced zero");
    reply(0);
  endtask

  task automatic t_late_reply();
    pulse_crate(11);
    pulse_cmd(mk_cmd(1, 1, 6, 3, 0));
    expect_msg(11, 6, 3, 0, 0, "R8 first");
    timeout();
    reply(1);
    check(ready == 1 && timed_out == 1, "R8 late reply ignored", {ready, timed_out}, 3);
    pulse_rd();
    expect_msg(11, 7, 0, 0, 0, "R8 late Q unused");
    reply(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pacing();
    t_read();
    t_write();
    t_control_tmo();
    t_busy();
    t_no_repeat();
    t_repeat_same();
    t_scan();
    t_late_reply();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule